// File: doc/BRIEF.md
# PHY Status Register with Event-Latching Bits

This block holds a 16-bit read-only status word for an Ethernet PHY, sampled by a management read interface. The word carries six fixed ability bits that always read 1, a live flag for auto-negotiation completion, and two event-latching flags. Reserved positions read 0.

The remote-fault flag is sticky high. One cycle of fault sets it, and it stays set until the register is read. The link flag is sticky low. One cycle of link loss clears it, and it stays clear until the register is read. Because of this, a short fault or a short link dropout between two reads always shows in the second read. A read returns the word present in the cycle of the read strobe. On the following edge both flags reload from the current inputs. An event that arrives in the read cycle is kept for the next read.

The event inputs and the read strobe are synchronous to the register clock. The strobe is a single-cycle pulse.

Top module: `phy_status_reg`

## Requirements
- R1: Bits 14, 13, 12, 11 (speed and duplex abilities), bit 3 (auto-negotiation ability) and bit 0 (extended registers present) always read 1, including during reset.
- R2: Bits 15, 10 down to 6, and 1 always read 0.
- R3: Bit 5 equals the value autoNegDone had at the previous rising clock edge.
- R4: Outside a read, a cycle with remoteFault at 1 makes bit 4 read 1 after the next edge. Bit 4 then stays 1 until an edge where readStrobe is 1.
- R5: After an edge with readStrobe at 1, bit 4 equals the remoteFault value of that read cycle. A fault in the read cycle is therefore kept for the next read.
- R6: Outside a read, a cycle with linkUp at 0 makes bit 2 read 0 after the next edge. Bit 2 then stays 0 until an edge where readStrobe is 1, even if the link returns.
- R7: After an edge with readStrobe at 1, bit 2 equals the linkUp value of that read cycle. A link that is still down stays 0.
- R8: The word present while readStrobe is 1 is the word before that read's reload. A fault or link event in the same cycle does not appear in that word.
- R9: While reset is active, and on the first edge after it is released, bits 5, 4 and 2 are 0. The word is 16'h7809.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| linkUp | input | 1 | Live link-established level |
| remoteFault | input | 1 | Live remote-fault detected level |
| autoNegDone | input | 1 | Live auto-negotiation complete level |
| readStrobe | input | 1 | Single-cycle pulse marking a management read |
| statusWord | output | 16 | Current register value |

## Verification
Bits 5, 4 and 2 are due one rising edge after the input cycle that causes them. The fixed and reserved bits never change. The value returned by a read is the word already present in the read cycle. The driver pushes the expected word for the next edge into a queue, and the monitor compares it at the following falling edge, so every check falls exactly one register stage after its stimulus. Read-cycle captures are compared a moment after the strobe is driven and before the edge that reloads the flags.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int WORD_W = 16;

  // Bit positions decoded by management software
  localparam int POS_FD100    = 14;
  localparam int POS_HD100    = 13;
  localparam int POS_FD10     = 12;
  localparam int POS_HD10     = 11;
  localparam int POS_NEG_DONE = 5;
  localparam int POS_FAULT    = 4;
  localparam int POS_AN_ABLE  = 3;
  localparam int POS_LINK     = 2;
  localparam int POS_EXT      = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic reloadFault;
    logic reloadLink;
    logic sampleNeg;
  } ctlStrobes_t;

  function automatic logic [WORD_W-1:0] fixedOnes();
    logic [WORD_W-1:0] m;
    m = '0;
    m[POS_FD100]   = 1'b1;
    m[POS_HD100]   = 1'b1;
    m[POS_FD10]    = 1'b1;
    m[POS_HD10]    = 1'b1;
    m[POS_AN_ABLE] = 1'b1;
    m[POS_EXT]     = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/psr_sticky_bit.sv
module psr_sticky_bit #(
  parameter bit LATCH_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic reload,
  output logic q
);

  logic nextQ;

  generate
    if (LATCH_HIGH) begin : g_high
      // Any 1 sticks until a reload
      always_comb nextQ = reload ? live : (q | live);
    end else begin : g_low
      // Any 0 sticks until a reload
      always_comb nextQ = reload ? live : (q & live);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nextQ;
  end

endmodule

// File: rtl/psr_control.sv
module psr_control
  import psr_pkg::*;
(
  input  logic        readStrobe,
  output ctlStrobes_t ctl
);

  always_comb begin
    ctl.reloadFault = readStrobe;
    ctl.reloadLink  = readStrobe;
    ctl.sampleNeg   = 1'b1;
  end

endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         linkUp,
  input  logic         remoteFault,
  input  logic         autoNegDone,
  input  ctlStrobes_t  ctl,
  output logic [W-1:0] statusWord
);

  localparam logic [W-1:0] FIXED_MASK = W'(fixedOnes());

  logic negDoneQ;
  logic faultQ;
  logic linkQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             negDoneQ <= 1'b0;
    else if (ctl.sampleNeg) negDoneQ <= autoNegDone;
  end

  psr_sticky_bit #(.LATCH_HIGH(1'b1)) u_fault (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (remoteFault),
    .reload (ctl.reloadFault),
    .q      (faultQ)
  );

  psr_sticky_bit #(.LATCH_HIGH(1'b0)) u_link (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (linkUp),
    .reload (ctl.reloadLink),
    .q      (linkQ)
  );

  always_comb begin
    statusWord               = FIXED_MASK;
    statusWord[POS_NEG_DONE] = negDoneQ;
    statusWord[POS_FAULT]    = faultQ;
    statusWord[POS_LINK]     = linkQ;
  end

endmodule

// File: rtl/phy_status_reg.sv
module phy_status_reg
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              linkUp,
  input  logic              remoteFault,
  input  logic              autoNegDone,
  input  logic              readStrobe,
  output logic [WORD_W-1:0] statusWord
);

  ctlStrobes_t ctl;

  psr_control u_ctl (
    .readStrobe (readStrobe),
    .ctl        (ctl)
  );

  psr_datapath #(.W(WORD_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .linkUp      (linkUp),
    .remoteFault (remoteFault),
    .autoNegDone (autoNegDone),
    .ctl         (ctl),
    .statusWord  (statusWord)
  );

endmodule

// File: rtl/psr_checker.sv
module psr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        linkUp,
  input logic        remoteFault,
  input logic        autoNegDone,
  input logic        readStrobe,
  input logic [15:0] statusWord
);

  a_r1_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    statusWord[14:11] == 4'hF && statusWord[3] && statusWord[0]);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !statusWord[15] && statusWord[10:6] == 5'h0 && !statusWord[1]);

  a_r3_neg_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> statusWord[5] == $past(autoNegDone));

  a_r4_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    remoteFault |=> statusWord[4]);

  a_r4_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[4] && !readStrobe) |=> statusWord[4]);

  a_r5_fault_reload: assert property (@(posedge clk) disable iff (!rst_n)
    readStrobe |=> statusWord[4] == $past(remoteFault));

  a_r6_link_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !linkUp |=> !statusWord[2]);

  a_r6_link_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!statusWord[2] && !readStrobe) |=> !statusWord[2]);

  a_r7_link_reload: assert property (@(posedge clk) disable iff (!rst_n)
    readStrobe |=> statusWord[2] == $past(linkUp));

  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> statusWord == 16'h7809);

endmodule

bind phy_status_reg psr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .linkUp      (linkUp),
  .remoteFault (remoteFault),
  .autoNegDone (autoNegDone),
  .readStrobe  (readStrobe),
  .statusWord  (statusWord)
);

// File: tb/phy_status_reg_test.sv
module phy_status_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        linkUp = 1'b0;
  logic        remoteFault = 1'b0;
  logic        autoNegDone = 1'b0;
  logic        readStrobe = 1'b0;
  logic [15:0] statusWord;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  // Bench model of the sticky flags
  logic mNeg = 1'b0, mFault = 1'b0, mLink = 1'b0;

  always #10 clk = ~clk;

  phy_status_reg uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .linkUp      (linkUp),
    .remoteFault (remoteFault),
    .autoNegDone (autoNegDone),
    .readStrobe  (readStrobe),
    .statusWord  (statusWord)
  );

  function automatic logic [15:0] modelWord();
    logic [15:0] w;
    w = 16'h7809;
    w[5] = mNeg;
    w[4] = mFault;
    w[2] = mLink;
    return w;
  endfunction

  task automatic compare(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected word for the next edge queued
  task automatic step(input logic lk, input logic f, input logic an,
                      input logic rd, input string tag);
    @(negedge clk);
    #1;
    linkUp = lk;
    remoteFault = f;
    autoNegDone = an;
    readStrobe = rd;
    if (rd) begin
      #1;
      compare(statusWord, modelWord(), "R8 word captured in read cycle");
    end
    mNeg = an;
    if (rd) begin
      mFault = f;
      mLink = lk;
    end else begin
      mFault = mFault | f;
      mLink = mLink & lk;
    end
    expQ.push_back(modelWord());
    tagQ.push_back(tag);
  endtask

  // Monitor: compare one queued item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        compare(statusWord, e, t);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(statusWord, 16'h7809, "R9 R1 R2 word during reset");
    rst_n = 1'b1;

    // Link comes up; needs a read to report it (R7)
    step(1, 0, 0, 0, "R6 link flag held low from reset");
    step(1, 0, 0, 1, "R7 read reloads link up");
    step(1, 0, 0, 0, "R1 R2 idle with link up");
    step(1, 0, 0, 0, "R6 link stays up continuously");

    // Auto-negotiation flag follows its input
    step(1, 0, 1, 0, "R3 negotiation done rises");
    step(1, 0, 1, 0, "R3 negotiation done held");
    step(1, 0, 0, 0, "R3 negotiation done falls");
    step(1, 0, 1, 0, "R3 negotiation done again");

    // Short fault pulse between reads
    step(1, 1, 1, 0, "R4 fault pulse sets flag");
    step(1, 0, 1, 0, "R4 fault flag holds");
    step(1, 0, 1, 0, "R4 fault flag holds later");
    step(1, 0, 1, 1, "R5 read clears fault flag");
    step(1, 0, 1, 0, "R5 fault flag stays clear");

    // Short link dropout between reads
    step(0, 0, 1, 0, "R6 link dropout clears flag");
    step(1, 0, 1, 0, "R6 link flag stays low after return");
    step(1, 0, 1, 0, "R6 link flag still low");
    step(1, 0, 1, 1, "R7 read with link up restores flag");
    step(1, 0, 1, 0, "R7 link flag stays up");

    // Fault arriving in the read cycle
    step(1, 1, 1, 1, "R5 fault during read kept");
    step(1, 0, 1, 0, "R4 kept fault still set");
    step(1, 0, 1, 1, "R5 read after kept fault clears");

    // Read while link is still down
    step(0, 0, 1, 0, "R6 link down");
    step(0, 0, 1, 1, "R7 read with link down stays low");
    step(1, 0, 1, 0, "R6 link returns, flag low");
    step(1, 0, 1, 1, "R7 read restores link flag");

    // Link drop in the read cycle
    step(0, 0, 1, 1, "R7 link drop during read");
    step(1, 0, 1, 0, "R6 drop from read cycle kept");

    // Fault and link drop together, then a read with a held fault input
    step(0, 1, 0, 0, "R4 R6 fault and drop together");
    step(1, 1, 0, 1, "R5 read with fault still high");
    step(1, 0, 0, 0, "R4 held fault reported");
    step(1, 0, 0, 0, "R1 R2 idle tail");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule